// File: doc/BRIEF.md
# Erased Memory Verification Sequencer

This controller gates the programming stage of a device that holds two non-volatile arrays: a one-time-programmable (OTP) array and a byte-erasable EEPROM array. It leaves reset in an idle state and at once starts a scan of the OTP array. The scan goes through a synchronous read port from the lowest address to the highest, and it requires every byte to read as 0x00. If a written byte is found, the red indicator latches on and the sequencer halts until the next reset. If the whole array is blank, the green indicator lights. The sequencer then waits, for as long as needed, for an enable input to go high.

Once enabled, the sequencer drives an erase pulse for the EEPROM array for a fixed number of clock cycles, set by a parameter. The nominal hardware value is 2.5 s at a 4 MHz clock, which is ten million cycles. After the pulse it scans the EEPROM array and requires every byte to read 0xFF. A failure raises the red indicator and halts before any security-clear action. On success it issues a single security-clear strobe and then raises a sticky ready flag that releases the programming stage.

Both scans share one scanner design, instantiated once for each array. The erase pulse comes from a separate cycle timer.

Top module: `erase_verify_seq`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, `led_red`, `led_green`, `prog_ready`, `erase_pulse` and `sec_clear` are all 0.
- R2: After reset the OTP array is read once at every address, in strictly ascending order from 0 to OTP_DEPTH-1. Read data is taken one cycle after `otp_rd`, and each byte is compared against 0x00.
- R3: If the OTP byte at index k is not 0x00, the scan stops after exactly k+1 reads. `led_red` then stays 1 and `led_green` stays 0 until reset. No erase pulse, EEPROM read, security strobe or ready is ever produced, even with `arm_en` high.
- R4: `led_green` is 0 until all OTP_DEPTH OTP bytes have been read and found to be 0x00. It goes to 1 once the OTP check passes.
- R5: After the OTP check passes and while `arm_en` is 0, the sequencer waits indefinitely. During the wait there is no erase pulse and no EEPROM read, and `led_green` stays 1.
- R6: The cycle after `arm_en` is seen high in the waiting state, `erase_pulse` goes high. It stays high for exactly ERASE_CYCLES consecutive cycles, and it occurs only once per run.
- R7: After the erase pulse the EEPROM array is read once at every address, ascending from 0 to EE_DEPTH-1, and each byte is compared against 0xFF.
- R8: If any EEPROM byte is not 0xFF, `led_red` goes to 1 and `led_green` goes to 0, and both stay so until reset. `sec_clear` and `prog_ready` never go high.
- R9: When both arrays pass, `sec_clear` is high for exactly one cycle. `prog_ready` rises in the following cycle. `prog_ready` and `led_green` then stay 1 and `led_red` stays 0 until reset.
- R10: A reset in the middle of a run returns the sequencer to idle with both indicators off. When reset is released, the whole sequence reruns from OTP address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_en | input | 1 | Enable that lets the EEPROM erase start after the OTP check |
| otp_rd | output | 1 | OTP read strobe |
| otp_addr | output | OTP_AW | OTP read address |
| otp_data | input | DATA_W | OTP read data, valid one cycle after `otp_rd` |
| ee_rd | output | 1 | EEPROM read strobe |
| ee_addr | output | EE_AW | EEPROM read address |
| ee_data | input | DATA_W | EEPROM read data, valid one cycle after `ee_rd` |
| erase_pulse | output | 1 | EEPROM erase command, high for ERASE_CYCLES cycles |
| sec_clear | output | 1 | One-cycle strobe that clears the security byte |
| led_red | output | 1 | Fault indicator |
| led_green | output | 1 | Pass indicator |
| prog_ready | output | 1 | Programming release flag |

## Verification
The assertions assume that both memories return data exactly one cycle after a read strobe, and that `arm_en` changes only away from the clock edge. To meet this, the bench models each array as a register that loads on the rising edge when the strobe is high, and it drives `arm_en` and reset only on falling edges. The assertions also assume the scanners are started only while idle, which the sequencer itself ensures. The bench's modelled EEPROM becomes 0xFF only while `erase_pulse` is high, except for one byte that can be held stuck so that the EEPROM check fails. Because of this, any read of the EEPROM before the erase would show up as a failed check.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OTP,
        ST_WAIT,
        ST_ERASE,
        ST_EE,
        ST_SEC,
        ST_READY,
        ST_FAULT
    } seq_state_t;

    typedef struct packed {
        seq_state_t st;
    } seq_regs_t;

endpackage

// File: rtl/evs_scan.sv
module evs_scan #(
    parameter int          DEPTH  = 64,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  ERASED = 8'h00,
    parameter int          AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic [AW-1:0]     addr,
    output logic              pass,
    output logic              fail
);

    localparam logic [AW-1:0]     LAST    = AW'(DEPTH - 1);
    localparam logic [DATA_W-1:0] BLANK_V = DATA_W'(ERASED);

    typedef struct packed {
        logic          active;
        logic [AW-1:0] addr;
        logic          pend;
        logic          pend_last;
    } scan_regs_t;

    scan_regs_t s_q, s_d;
    logic issue;

    always_comb begin
        s_d   = s_q;
        pass  = 1'b0;
        fail  = 1'b0;
        if (s_q.pend) begin
            if (rd_data != BLANK_V) begin
                fail        = 1'b1;
                s_d.active  = 1'b0;
            end else if (s_q.pend_last) begin
                pass = 1'b1;
            end
        end
        issue         = s_q.active && !fail;
        s_d.pend      = issue;
        s_d.pend_last = issue && (s_q.addr == LAST);
        if (issue) begin
            if (s_q.addr == LAST) begin
                s_d.active = 1'b0;
            end else begin
                s_d.addr = s_q.addr + 1'b1;
            end
        end
        if (go) begin
            s_d.active = 1'b1;
            s_d.addr   = '0;
        end
        rd_en = issue;
        addr  = s_q.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2 / R7: consecutive reads step the address up by one
    assert_addr_ascend_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (addr == AW'($past(addr) + 1'b1)));

    // R3: a failing compare stops further reads
    assert_stop_on_fail_R3: assert property (@(posedge clk) disable iff (rst)
        fail |=> !rd_en);

    // R2: a start request only arrives while the scanner is quiet
    assert_go_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        go |-> (!s_q.active && !s_q.pend));

    assert_pass_fail_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

endmodule

// File: rtl/evs_timer.sv
module evs_timer #(
    parameter int CYCLES = 1000,
    parameter int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done
);

    localparam logic [CW-1:0] END_CNT = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t t_q, t_d;

    always_comb begin
        t_d  = t_q;
        done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == END_CNT) begin
                t_d.busy = 1'b0;
                done     = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
        if (go) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
        end
        busy = t_q.busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R6: counter never runs past the programmed length
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        t_q.busy |-> (t_q.cnt <= END_CNT));

    // R6: the pulse ends right after the terminal count
    assert_end_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !go) |=> !busy);

endmodule

// File: rtl/erase_verify_seq.sv
module erase_verify_seq #(
    parameter int OTP_DEPTH    = 16384,
    parameter int EE_DEPTH     = 256,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 10_000_000,
    parameter int OTP_AW       = (OTP_DEPTH > 1) ? $clog2(OTP_DEPTH) : 1,
    parameter int EE_AW        = (EE_DEPTH > 1) ? $clog2(EE_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_en,
    output logic              otp_rd,
    output logic [OTP_AW-1:0] otp_addr,
    input  logic [DATA_W-1:0] otp_data,
    output logic              ee_rd,
    output logic [EE_AW-1:0]  ee_addr,
    input  logic [DATA_W-1:0] ee_data,
    output logic              erase_pulse,
    output logic              sec_clear,
    output logic              led_red,
    output logic              led_green,
    output logic              prog_ready
);

    import evs_pkg::*;

    seq_regs_t r_q, r_d;

    logic otp_go, otp_pass, otp_fail;
    logic ee_go, ee_pass, ee_fail;
    logic erase_go, erase_done;

    evs_scan #(
        .DEPTH  (OTP_DEPTH),
        .DATA_W (DATA_W),
        .ERASED (8'h00),
        .AW     (OTP_AW)
    ) u_otp_scan (
        .clk     (clk),
        .rst     (rst),
        .go      (otp_go),
        .rd_data (otp_data),
        .rd_en   (otp_rd),
        .addr    (otp_addr),
        .pass    (otp_pass),
        .fail    (otp_fail)
    );

    evs_scan #(
        .DEPTH  (EE_DEPTH),
        .DATA_W (DATA_W),
        .ERASED (8'hFF),
        .AW     (EE_AW)
    ) u_ee_scan (
        .clk     (clk),
        .rst     (rst),
        .go      (ee_go),
        .rd_data (ee_data),
        .rd_en   (ee_rd),
        .addr    (ee_addr),
        .pass    (ee_pass),
        .fail    (ee_fail)
    );

    evs_timer #(
        .CYCLES (ERASE_CYCLES)
    ) u_erase_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (erase_go),
        .busy (erase_pulse),
        .done (erase_done)
    );

    always_comb begin
        r_d      = r_q;
        otp_go   = 1'b0;
        ee_go    = 1'b0;
        erase_go = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                otp_go   = 1'b1;
                r_d.st   = ST_OTP;
            end
            ST_OTP: begin
                if (otp_fail)      r_d.st = ST_FAULT;
                else if (otp_pass) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (arm_en) begin
                    erase_go = 1'b1;
                    r_d.st   = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (erase_done) begin
                    ee_go  = 1'b1;
                    r_d.st = ST_EE;
                end
            end
            ST_EE: begin
                if (ee_fail)      r_d.st = ST_FAULT;
                else if (ee_pass) r_d.st = ST_SEC;
            end
            ST_SEC:   r_d.st = ST_READY;
            ST_READY: r_d.st = ST_READY;
            ST_FAULT: r_d.st = ST_FAULT;
            default:  r_d.st = ST_FAULT;
        endcase
        sec_clear  = (r_q.st == ST_SEC);
        prog_ready = (r_q.st == ST_READY);
        led_red    = (r_q.st == ST_FAULT);
        led_green  = (r_q.st == ST_WAIT) || (r_q.st == ST_ERASE) ||
                     (r_q.st == ST_EE)   || (r_q.st == ST_SEC)   ||
                     (r_q.st == ST_READY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R3 / R8: a fault is permanent
    assert_red_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        led_red |=> led_red);

    assert_leds_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(led_red && led_green));

    // R5: no EEPROM access while waiting for the enable
    assert_no_ee_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_WAIT) |-> (!ee_rd && !erase_pulse));

    // R6: the erase only starts after the enable was seen
    assert_erase_after_en_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_pulse) |-> $past(arm_en));

    // R9: security strobe is one cycle and precedes ready
    assert_sec_single_R9: assert property (@(posedge clk) disable iff (rst)
        sec_clear |=> (!sec_clear && prog_ready));

    assert_ready_after_sec_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_ready) |-> $past(sec_clear));

    assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        prog_ready |=> prog_ready);

endmodule

// File: tb/erase_verify_seq_bench.sv
module erase_verify_seq_bench;

    localparam int OTP_D = 32;
    localparam int EE_D  = 8;
    localparam int ER_C  = 40;
    localparam int OAW   = $clog2(OTP_D);
    localparam int EAW   = $clog2(EE_D);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           arm_en = 1'b0;
    logic           otp_rd, ee_rd;
    logic [OAW-1:0] otp_addr;
    logic [EAW-1:0] ee_addr;
    logic [7:0]     otp_data, ee_data;
    logic           erase_pulse, sec_clear, led_red, led_green, prog_ready;

    logic [7:0]     otp_mem [OTP_D];
    logic [EE_D-1:0] erased;
    int             stuck_idx = -1;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    int otp_reads, ee_reads, otp_next, ee_next, ord_err;
    int erase_cyc, erase_rises, sec_cnt, early_green, ee_early, ready_nosec;
    bit prev_erase;

    always #4 clk = ~clk;

    erase_verify_seq #(
        .OTP_DEPTH    (OTP_D),
        .EE_DEPTH     (EE_D),
        .DATA_W       (8),
        .ERASE_CYCLES (ER_C)
    ) u_erase_verify_seq (
        .clk         (clk),
        .rst         (rst),
        .arm_en      (arm_en),
        .otp_rd      (otp_rd),
        .otp_addr    (otp_addr),
        .otp_data    (otp_data),
        .ee_rd       (ee_rd),
        .ee_addr     (ee_addr),
        .ee_data     (ee_data),
        .erase_pulse (erase_pulse),
        .sec_clear   (sec_clear),
        .led_red     (led_red),
        .led_green   (led_green),
        .prog_ready  (prog_ready)
    );

    // memory models: registered read, one cycle latency
    always @(posedge clk) begin
        if (otp_rd) otp_data <= otp_mem[otp_addr];
        if (ee_rd)  ee_data  <= erased[ee_addr] ? 8'hFF : 8'h5A;
        if (rst) begin
            erased <= '0;
        end else if (erase_pulse) begin
            for (int i = 0; i < EE_D; i++)
                if (i != stuck_idx) erased[i] <= 1'b1;
        end
    end

    // port monitor
    always @(negedge clk) begin
        if (rst) begin
            otp_reads = 0; ee_reads = 0; otp_next = 0; ee_next = 0; ord_err = 0;
            erase_cyc = 0; erase_rises = 0; sec_cnt = 0; early_green = 0;
            ee_early = 0; ready_nosec = 0; prev_erase = 0;
        end else begin
            if (otp_rd) begin
                if (int'(otp_addr) != otp_next) ord_err++;
                otp_next++; otp_reads++;
            end
            if (ee_rd) begin
                if (int'(ee_addr) != ee_next) ord_err++;
                ee_next++; ee_reads++;
                if (erase_rises == 0 || erase_pulse) ee_early++;
            end
            if (erase_pulse) begin
                erase_cyc++;
                if (!prev_erase) erase_rises++;
            end
            prev_erase = erase_pulse;
            if (sec_clear) sec_cnt++;
            if (led_green && otp_reads < OTP_D) early_green++;
            if (prog_ready && sec_cnt == 0) ready_nosec++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_otp(input int bad_idx);
        for (int i = 0; i < OTP_D; i++) otp_mem[i] = (i == bad_idx) ? 8'h01 : 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // sel: 0 ready, 1 red, 2 green
    task automatic wait_out(input int sel, input int lim);
        for (int i = 0; i < lim; i++) begin
            if ((sel == 0 && prog_ready) || (sel == 1 && led_red) ||
                (sel == 2 && led_green)) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        fill_otp(-1); stuck_idx = -1; arm_en = 1'b1;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 red in reset", int'(led_red), 0);
        chk("R1 green in reset", int'(led_green), 0);
        chk("R1 ready/erase/sec in reset",
            int'(prog_ready) + int'(erase_pulse) + int'(sec_clear), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs first cycle after reset",
            int'(led_red) + int'(led_green) + int'(prog_ready) + int'(erase_pulse), 0);
    endtask

    task automatic check_pass_run(input string tag);
        wait_out(0, 2000);
        chk({"R9 ready ", tag}, int'(prog_ready), 1);
        chk({"R2 otp reads ", tag}, otp_reads, OTP_D);
        chk({"R2/R7 address order ", tag}, ord_err, 0);
        chk({"R4 green not early ", tag}, early_green, 0);
        chk({"R6 erase cycles ", tag}, erase_cyc, ER_C);
        chk({"R6 erase pulses ", tag}, erase_rises, 1);
        chk({"R7 ee reads ", tag}, ee_reads, EE_D);
        chk({"R7 ee read before erase end ", tag}, ee_early, 0);
        chk({"R9 ready after sec ", tag}, ready_nosec, 0);
        repeat (20) @(negedge clk);
        chk({"R9 sec strobe count ", tag}, sec_cnt, 1);
        chk({"R9 ready/green held ", tag},
            int'(prog_ready) + int'(led_green) + int'(!led_red), 3);
    endtask

    task automatic t_pass_armed();
        fill_otp(-1); stuck_idx = -1; arm_en = 1'b1;
        do_reset();
        check_pass_run("armed");
    endtask

    task automatic t_wait_enable();
        fill_otp(-1); stuck_idx = -1; arm_en = 1'b0;
        do_reset();
        repeat (300) @(negedge clk);
        chk("R4 green after otp pass", int'(led_green), 1);
        chk("R5 no erase while disabled", erase_rises, 0);
        chk("R5 no ee reads while disabled", ee_reads, 0);
        chk("R5 not ready while disabled", int'(prog_ready), 0);
        arm_en = 1'b1;
        @(negedge clk);
        arm_en = 1'b0;
        @(negedge clk);
        chk("R6 erase starts after enable", int'(erase_pulse), 1);
        check_pass_run("late enable");
    endtask

    task automatic t_otp_fail(input int k);
        fill_otp(k); stuck_idx = -1; arm_en = 1'b1;
        do_reset();
        wait_out(1, 500);
        repeat (100) @(negedge clk);
        chk($sformatf("R3 red at idx %0d", k), int'(led_red), 1);
        chk($sformatf("R3 green off idx %0d", k), int'(led_green), 0);
        chk($sformatf("R3 reads stop idx %0d", k), otp_reads, k + 1);
        chk($sformatf("R3 no erase/ee/sec/ready idx %0d", k),
            erase_rises + ee_reads + sec_cnt + int'(prog_ready), 0);
        chk($sformatf("R4 green never idx %0d", k), early_green, 0);
    endtask

    task automatic t_ee_fail();
        fill_otp(-1); stuck_idx = 3; arm_en = 1'b1;
        do_reset();
        wait_out(1, 2000);
        repeat (50) @(negedge clk);
        chk("R8 red on ee fail", int'(led_red), 1);
        chk("R8 green off on ee fail", int'(led_green), 0);
        chk("R8 no sec strobe", sec_cnt, 0);
        chk("R8 not ready", int'(prog_ready), 0);
        chk("R6 one erase before ee fail", erase_rises, 1);
        chk("R7 ee reads up to stuck byte", ee_reads, 4);
        stuck_idx = -1;
    endtask

    task automatic t_reset_mid();
        fill_otp(-1); stuck_idx = -1; arm_en = 1'b0;
        do_reset();
        wait_out(2, 500);
        chk("R10 green before mid reset", int'(led_green), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 indicators off after mid reset", int'(led_green) + int'(led_red), 0);
        rst = 1'b0;
        arm_en = 1'b1;
        check_pass_run("rerun");
    endtask

    initial begin
        fill_otp(-1);
        t_reset_state();
        t_pass_armed();
        t_wait_enable();
        t_otp_fail(0);
        t_otp_fail(13);
        t_otp_fail(OTP_D - 1);
        t_ee_fail();
        t_reset_mid();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule